// File: doc/BRIEF.md
# Bus-Snooping Freeze Trigger

This block sits on the expansion port of an 8-bit microprocessor system. It watches the address bus, the read/write line and a per-cycle strobe. A freeze request makes the running program jump into a routine held in an external ROM. Masked interrupts do not stop this, and neither does a program that has no interrupt source enabled.

When a request arrives, the block waits for a bus cycle that it can treat as an opcode fetch. During that cycle it tells the board to pull every data line low, so the CPU executes a BRK (opcode 0x00). A BRK runs whatever the interrupt-disable flag holds, so the CPU will next fetch its vector from 0xFFFE and then 0xFFFF. Before that fetch begins, the block has already enabled the external ROM and asked the board to hold address line A9 low. This moves the vector fetch to 0xFDFE/0xFDFF, which the ROM serves.

There are two ways to pick the injection cycle:
- **Vector mode** waits for a read of 0xFFFF, which means an interrupt is already vectoring. It then injects on the next strobed cycle.
- **Write mode** injects on the first read that follows one or more writes. A store instruction always ends with its write, so that read is an opcode fetch.

Top module: `fz_freeze_trigger`

## Requirements
- R1: A synchronous reset sets `status` to 0 (idle) and deasserts `force_zero`, `rom_en` and `a9_low`. This holds even when a freeze sequence is in progress.
- R2: In idle, a rising edge on `freeze_req` sets `status` to 1 (armed) at the next clock. A request level that stays high does not re-arm the block after a sequence completes.
- R3: Any request edge that arrives while `status` is not 0 is ignored, and the running sequence continues unchanged.
- R4: In vector mode (`mode`=0), an armed block that sees a strobed read of 0xFFFF moves to `status` 2 (injecting). It then asserts `force_zero` during the next strobed cycle and only while `bus_valid` is high.
- R5: In vector mode, other bus cycles leave the block armed and never force the data bus. This includes writes to 0xFFFF and reads of any other address.
- R6: In write mode (`mode`=1), the first strobed read after a run of one or more strobed writes asserts `force_zero` in that same cycle. Runs of two writes, as in read-modify-write instructions, are handled. A read with no write before it does not fire.
- R7: In write mode, a read of 0xFFFE that directly follows writes does not fire and cancels the pending write run. A later write is then needed before the block can fire.
- R8: From the clock after the forced cycle, `rom_en` and `a9_low` are high and `status` is 3 (redirecting). They stay high until a strobed read of 0xFFFE has been followed by a strobed read of 0xFFFF. At the clock after that read they fall and `status` returns to 0.
- R9: A strobed read of 0xFFFF while redirecting, with no read of 0xFFFE before it, does not end the redirection.
- R10: `force_zero` is asserted for exactly one strobed cycle per freeze sequence.
- R11: The trigger mode is sampled when the request edge arms the block. Changing `mode` while the block is armed has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | High for one clock per CPU bus cycle; address and direction are valid |
| bus_addr | input | 16 | CPU address bus |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| freeze_req | input | 1 | Freeze request (edge-captured) |
| mode | input | 1 | 0 = vector-read trigger, 1 = write-triggered injection |
| force_zero | output | 1 | Drive all data bus bits low during this strobed cycle |
| rom_en | output | 1 | Enable the external freeze ROM |
| a9_low | output | 1 | Hold address line A9 low |
| status | output | 2 | 0 idle, 1 armed, 2 injecting, 3 redirecting |

## Verification
`force_zero` is combinational on the strobe, so it is due in the same cycle as the strobed access. The bench drives each bus cycle at a falling edge and reads `force_zero` one time unit later, before the rising edge. `status`, `rom_en` and `a9_low` are registered and change one clock after the strobe or request edge that causes them. The bench reads them at the falling edge that follows that rising edge. Every bus cycle is followed by one idle clock, so each registered result is read after exactly one edge.

// File: rtl/fz_pkg.sv
package fz_pkg;
    localparam int unsigned FZ_ADDR_W = 16;
    localparam logic [FZ_ADDR_W-1:0] FZ_VEC_LO = 16'hFFFE;

    typedef enum logic [1:0] {
        FZ_IDLE   = 2'd0,
        FZ_ARMED  = 2'd1,
        FZ_INJECT = 2'd2,
        FZ_REDIR  = 2'd3
    } fz_state_e;

    typedef enum logic {
        TRIG_VECTOR = 1'b0,
        TRIG_WRITE  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic valid;
        logic rd;
        logic hit_lo;
        logic hit_hi;
    } bus_snoop_t;

    function automatic logic strobed_read(input bus_snoop_t s);
        return s.valid && s.rd;
    endfunction

    function automatic logic strobed_write(input bus_snoop_t s);
        return s.valid && !s.rd;
    endfunction
endpackage

// File: rtl/fz_req_edge.sv
module fz_req_edge (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic req_rise
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req;
    end

    assign req_rise = req && !req_q;
endmodule

// File: rtl/fz_addr_match.sv
module fz_addr_match
    import fz_pkg::*;
#(
    parameter int unsigned ADDR_W = FZ_ADDR_W,
    parameter logic [ADDR_W-1:0] VEC_LO = FZ_VEC_LO
) (
    input  logic              valid,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output bus_snoop_t        snoop
);
    localparam logic [ADDR_W-1:0] VEC_HI = VEC_LO | ADDR_W'(1);

    always_comb begin
        snoop.valid  = valid;
        snoop.rd     = rd;
        snoop.hit_lo = (addr == VEC_LO);
        snoop.hit_hi = (addr == VEC_HI);
    end
endmodule

// File: rtl/fz_seq.sv
module fz_seq
    import fz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_rise,
    input  logic       mode,
    input  bus_snoop_t snoop,
    output fz_state_e  state,
    output logic       force_zero,
    output logic       redirect
);
    fz_state_e  state_d;
    trig_mode_e mode_q;
    logic       saw_write, saw_write_d;
    logic       got_lo, got_lo_d;
    logic       fire_write;

    // write-mode fire: first read after a write run, unless it is the low vector byte
    assign fire_write = (state == FZ_ARMED) && (mode_q == TRIG_WRITE) && saw_write
                        && strobed_read(snoop) && !snoop.hit_lo;

    assign force_zero = fire_write || ((state == FZ_INJECT) && snoop.valid);
    assign redirect   = (state == FZ_REDIR);

    always_comb begin
        state_d     = state;
        saw_write_d = saw_write;
        got_lo_d    = got_lo;
        unique case (state)
            FZ_IDLE: begin
                saw_write_d = 1'b0;
                got_lo_d    = 1'b0;
                if (req_rise) state_d = FZ_ARMED;
            end
            FZ_ARMED: begin
                if (mode_q == TRIG_VECTOR) begin
                    if (strobed_read(snoop) && snoop.hit_hi) state_d = FZ_INJECT;
                end else begin
                    if (strobed_write(snoop)) saw_write_d = 1'b1;
                    else if (fire_write)     state_d = FZ_REDIR;
                    else if (strobed_read(snoop)) saw_write_d = 1'b0;
                end
            end
            FZ_INJECT: begin
                if (snoop.valid) state_d = FZ_REDIR;
            end
            FZ_REDIR: begin
                if (strobed_read(snoop) && snoop.hit_lo) got_lo_d = 1'b1;
                else if (strobed_read(snoop) && snoop.hit_hi && got_lo) state_d = FZ_IDLE;
            end
            default: state_d = FZ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FZ_IDLE;
            mode_q    <= TRIG_VECTOR;
            saw_write <= 1'b0;
            got_lo    <= 1'b0;
        end else begin
            state     <= state_d;
            saw_write <= saw_write_d;
            got_lo    <= got_lo_d;
            if (state == FZ_IDLE && req_rise) mode_q <= trig_mode_e'(mode);
        end
    end

    // R2: an edge in idle arms the block
    p_arm_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (state == FZ_IDLE && req_rise) |=> (state == FZ_ARMED));

    // R3: an edge while busy never re-arms
    p_busy_ignores_req_r3: assert property (@(posedge clk) disable iff (rst)
        (state == FZ_REDIR && req_rise && !(strobed_read(snoop) && snoop.hit_hi)) |=> (state == FZ_REDIR));

    // R4: forcing only in a strobed cycle
    p_force_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        force_zero |-> snoop.valid);

    // R10: forcing never lasts into a second cycle
    p_force_one_shot_r10: assert property (@(posedge clk) disable iff (rst)
        force_zero |=> !force_zero);

    // R8: redirection follows the forced cycle
    p_redirect_after_force_r8: assert property (@(posedge clk) disable iff (rst)
        force_zero |=> redirect);

    // R9: redirection holds until the high vector byte is read
    p_redirect_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (redirect && !(strobed_read(snoop) && snoop.hit_hi)) |=> redirect);
endmodule

// File: rtl/fz_freeze_trigger.sv
module fz_freeze_trigger
    import fz_pkg::*;
#(
    parameter int unsigned ADDR_W = FZ_ADDR_W,
    parameter logic [ADDR_W-1:0] VEC_LO = FZ_VEC_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              freeze_req,
    input  logic              mode,
    output logic              force_zero,
    output logic              rom_en,
    output logic              a9_low,
    output logic [1:0]        status
);
    logic       req_rise;
    bus_snoop_t snoop;
    fz_state_e  state;
    logic       redirect;

    fz_req_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .req      (freeze_req),
        .req_rise (req_rise)
    );

    fz_addr_match #(.ADDR_W(ADDR_W), .VEC_LO(VEC_LO)) u_match (
        .valid (bus_valid),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .snoop (snoop)
    );

    fz_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_rise   (req_rise),
        .mode       (mode),
        .snoop      (snoop),
        .state      (state),
        .force_zero (force_zero),
        .redirect   (redirect)
    );

    assign rom_en = redirect;
    assign a9_low = redirect;
    assign status = state;

    // R1: nothing overrides the bus in the cycle after reset
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!rom_en && !a9_low && status == 2'd0));
endmodule

// File: tb/tb_fz_freeze_trigger.sv
module tb_fz_freeze_trigger;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b1;
    logic        freeze_req = 1'b0;
    logic        mode = 1'b0;
    logic        force_zero, rom_en, a9_low;
    logic [1:0]  status;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    fz_freeze_trigger dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .freeze_req(freeze_req), .mode(mode),
        .force_zero(force_zero), .rom_en(rom_en), .a9_low(a9_low), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobed CPU cycle followed by an idle clock; fz is sampled before the edge
    task automatic cpu(input logic [15:0] a, input logic rd, output logic fz);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_rd = rd;
        #1 fz = force_zero;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse_req(input logic m);
        @(negedge clk);
        mode = m; freeze_req = 1'b1;
        @(negedge clk);
        freeze_req = 1'b0;
    endtask

    task automatic finish_vectors(input string tag);
        logic fz;
        cpu(16'hFFFE, 1'b1, fz);
        chk({tag, " R8 lo read keeps a9"}, a9_low, 1);
        cpu(16'hFFFF, 1'b1, fz);
        chk({tag, " R8 status idle"}, status, 0);
        chk({tag, " R8 a9 released"}, a9_low, 0);
        chk({tag, " R8 rom released"}, rom_en, 0);
    endtask

    task automatic t_reset();
        chk("R1 status", status, 0);
        chk("R1 rom_en", rom_en, 0);
        chk("R1 a9_low", a9_low, 0);
        chk("R1 force_zero", force_zero, 0);
    endtask

    task automatic t_vector();
        logic fz;
        pulse_req(1'b0);
        chk("R2 armed", status, 1);
        cpu(16'h1234, 1'b1, fz);
        chk("R5 plain read no force", fz, 0);
        cpu(16'hFFFF, 1'b0, fz);
        chk("R5 write FFFF no force", fz, 0);
        chk("R5 still armed", status, 1);
        cpu(16'hFFFF, 1'b1, fz);
        chk("R4 no force on trigger", fz, 0);
        chk("R4 injecting", status, 2);
        @(negedge clk); #1;
        chk("R4 no force without strobe", force_zero, 0);
        cpu(16'h2000, 1'b1, fz);
        chk("R4 forced next strobe", fz, 1);
        chk("R8 redirecting", status, 3);
        chk("R8 a9_low", a9_low, 1);
        chk("R8 rom_en", rom_en, 1);
        cpu(16'h0105, 1'b0, fz);
        chk("R10 no second force", fz, 0);
        cpu(16'hFFFF, 1'b1, fz);
        chk("R9 hi first keeps redirect", status, 3);
        pulse_req(1'b1);
        chk("R3 busy ignores request", status, 3);
        finish_vectors("vec");
    endtask

    task automatic t_write();
        logic fz;
        pulse_req(1'b1);
        cpu(16'h1000, 1'b1, fz);
        chk("R6 read without write no force", fz, 0);
        chk("R6 still armed", status, 1);
        cpu(16'h0200, 1'b0, fz);
        cpu(16'h0200, 1'b0, fz);
        chk("R6 no force on write", fz, 0);
        cpu(16'h1003, 1'b1, fz);
        chk("R6 force after write run", fz, 1);
        chk("R6 redirecting", status, 3);
        finish_vectors("wr");
    endtask

    task automatic t_write_irq();
        logic fz;
        pulse_req(1'b1);
        cpu(16'h01FF, 1'b0, fz);
        cpu(16'h01FE, 1'b0, fz);
        cpu(16'hFFFE, 1'b1, fz);
        chk("R7 vector lo read no force", fz, 0);
        chk("R7 still armed", status, 1);
        cpu(16'hFFFF, 1'b1, fz);
        chk("R7 hi read no force", fz, 0);
        cpu(16'hC000, 1'b1, fz);
        chk("R7 write run cancelled", fz, 0);
        cpu(16'h0300, 1'b0, fz);
        cpu(16'hC010, 1'b1, fz);
        chk("R7 fires after new write", fz, 1);
        finish_vectors("irq");
    endtask

    task automatic t_mode_latch();
        logic fz;
        pulse_req(1'b0);
        mode = 1'b1;
        cpu(16'h0400, 1'b0, fz);
        cpu(16'h5000, 1'b1, fz);
        chk("R11 mode change ignored", fz, 0);
        chk("R11 still armed", status, 1);
        cpu(16'hFFFF, 1'b1, fz);
        chk("R11 vector trigger", status, 2);
        cpu(16'h6000, 1'b1, fz);
        chk("R11 forced", fz, 1);
        finish_vectors("mode");
    endtask

    task automatic t_level_and_reset();
        logic fz;
        @(negedge clk);
        mode = 1'b0; freeze_req = 1'b1;
        @(negedge clk);
        chk("R2 level arms", status, 1);
        cpu(16'hFFFF, 1'b1, fz);
        cpu(16'h7000, 1'b1, fz);
        finish_vectors("lvl");
        @(negedge clk); @(negedge clk);
        chk("R2 held level no rearm", status, 0);
        freeze_req = 1'b0;
        pulse_req(1'b1);
        cpu(16'h0200, 1'b0, fz);
        cpu(16'h8000, 1'b1, fz);
        chk("R1 pre-reset redirect", status, 3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset status", status, 0);
        chk("R1 reset a9", a9_low, 0);
        chk("R1 reset rom", rom_en, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_vector();
        t_write();
        t_write_irq();
        t_mode_latch();
        t_level_and_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule